// File: doc/BRIEF.md
# UART Character Frame Codec

This block turns one asynchronous serial character into its parallel frame image and back. The transmit path takes a data byte and a set of line-control fields and lays out the character bits from bit 0 upward. First come the data bits, least significant first. An optional parity bit follows, then one or two stop bits. The start bit is not part of the image. The receive path takes a frame image in the same layout and the same line-control fields. It returns the data, a parity-error flag and a framing-error flag.

A third path gives the length of one character in half-bit units, counted against the 16-bit baud divisor. The half-bit unit keeps the one-and-a-half stop-bit case an integer. All three paths are computed combinationally and captured in one register stage. Every output therefore reflects the inputs present at the previous rising clock edge. A serializer or a character timer above this block consumes the outputs. Wire-level shifting and baud generation are left to those neighbours.

Top module: `uart_frame_codec`

## Requirements
- R1: The word length n is 5 plus `lc_wlen` (0..3 gives 5..8 bits). Data bit i of `tx_byte` appears at `tx_frame[i]` for i < n.
- R2: Data bits at or above n are zero in `rx_result[7:0]`. `tx_frame` bits at or above `tx_bits` are zero.
- R3: With `lc_par_en`=1 and `lc_stick`=0, `tx_frame[n]` carries the XOR of the n data bits when `lc_even`=1, and the inverse of that XOR when `lc_even`=0.
- R4: With `lc_par_en`=1 and `lc_stick`=1, `tx_frame[n]` is 1 whatever the data and `lc_even`.
- R5: On receive, with parity enabled and non-stick, the XOR of the n data bits and bit n must be 0 for even and 1 for odd. Otherwise `rx_result[8]` is set.
- R6: On receive, with stick parity, `rx_result[8]` is set exactly when bit n is 0. `lc_even` has no effect on this.
- R7: The first stop bit sits at position s = n + `lc_par_en` and is 1. When `lc_two_stop`=1, a second stop bit of 1 sits at s+1. `tx_bits` = s + 1 + `lc_two_stop`.
- R8: `rx_result[9]` is set when bit s is 0, or when `lc_two_stop`=1 and bit s+1 is 0. Bit s+1 is ignored when `lc_two_stop`=0.
- R9: `char_half` = divisor × (2·(1 + n + `lc_par_en`) + h). The stop count h is 2 for one stop bit, 3 for two stop bits with n = 5, and 4 for two stop bits with n > 5.
- R10: `rx_result` holds the data in bits 7:0, the parity error in bit 8 and the framing error in bit 9. Bit 8 stays 0 whenever parity is disabled.
- R11: While `rst_n` is low all outputs are zero. After reset, outputs change one clock after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_wlen | input | 2 | Word length select, n = 5 + value |
| lc_par_en | input | 1 | Parity bit present |
| lc_stick | input | 1 | Stick parity (bit forced to 1) |
| lc_even | input | 1 | Even parity when 1, odd when 0 |
| lc_two_stop | input | 1 | Second stop bit (1.5 bit times when n = 5) |
| div_val | input | 16 | Baud divisor |
| tx_byte | input | 8 | Character to frame |
| rx_frame | input | 11 | Received frame image |
| tx_frame | output | 11 | Built frame image |
| tx_bits | output | 4 | Number of frame bits used in tx_frame |
| rx_result | output | 10 | {framing error, parity error, data} |
| char_half | output | 21 | Character length in half-bit divisor units |

## Verification
The bench uses the default widths: an 8-bit maximum word, an 11-bit frame image and a 16-bit divisor. These cover every word length from 5 to 8 and every parity and stop combination, including the odd-valued 1.5-stop durations. The full divisor range is reachable, up to the largest duration 65535 × 24. Each transmitted frame is fed back into the receive path with the same settings, and this must decode clean. Hand-built frames then corrupt one parity or stop position at a time.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int UFC_DATA_W  = 8;
  localparam int UFC_MIN_W   = 5;
  localparam int UFC_FRAME_W = UFC_DATA_W + 3;
  localparam int UFC_IDX_W   = $clog2(UFC_FRAME_W + 1);
  localparam int UFC_DIV_W   = 16;
  localparam int UFC_UNIT_W  = $clog2(2 * (UFC_FRAME_W + 1) + 1);

  // word length from the two select bits
  function automatic logic [UFC_IDX_W-1:0] ufc_word_len(input logic [1:0] wlen);
    return UFC_IDX_W'(UFC_MIN_W) + UFC_IDX_W'(wlen);
  endfunction

  // stop interval in half-bit units
  function automatic logic [2:0] ufc_stop_halves(input logic [1:0] wlen, input logic two);
    if (!two)            return 3'd2;
    else if (wlen == 2'd0) return 3'd3;
    else                 return 3'd4;
  endfunction

  // parity bit value to place after the data
  function automatic logic ufc_par_bit(input logic data_xor, input logic stick, input logic even);
    if (stick) return 1'b1;
    return even ? data_xor : ~data_xor;
  endfunction
endpackage

// File: rtl/ufc_packer.sv
module ufc_packer
  import uart_frame_pkg::*;
#(
  parameter int DATA_W  = UFC_DATA_W,
  parameter int FRAME_W = UFC_FRAME_W,
  parameter int IDX_W   = UFC_IDX_W
) (
  input  logic [1:0]         wlen,
  input  logic               par_en,
  input  logic               stick,
  input  logic               even,
  input  logic               two_stop,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [IDX_W-1:0]   bits
);
  logic [IDX_W-1:0]  n;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] kept;
  logic              pbit;
  logic [IDX_W-1:0]  pos;

  assign n = ufc_word_len(wlen);

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (n > IDX_W'(g));
  end

  assign kept = data & mask;
  assign pbit = ufc_par_bit(^kept, stick, even);

  always_comb begin
    frame = '0;
    frame[DATA_W-1:0] = kept;
    pos = n;
    if (par_en) begin
      frame[pos] = pbit;
      pos = pos + IDX_W'(1);
    end
    frame[pos] = 1'b1;
    if (two_stop) frame[pos + IDX_W'(1)] = 1'b1;
    bits = pos + IDX_W'(1) + IDX_W'(two_stop);
  end
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker
  import uart_frame_pkg::*;
#(
  parameter int DATA_W  = UFC_DATA_W,
  parameter int FRAME_W = UFC_FRAME_W,
  parameter int IDX_W   = UFC_IDX_W
) (
  input  logic [1:0]         wlen,
  input  logic               par_en,
  input  logic               stick,
  input  logic               even,
  input  logic               two_stop,
  input  logic [FRAME_W-1:0] frame,
  output logic [DATA_W-1:0]  data,
  output logic               par_err,
  output logic               frm_err
);
  logic [IDX_W-1:0]  n;
  logic [IDX_W-1:0]  spos;
  logic [DATA_W-1:0] mask;
  logic              pbit;
  logic              sum;

  assign n = ufc_word_len(wlen);

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (n > IDX_W'(g));
  end

  assign data = frame[DATA_W-1:0] & mask;
  assign pbit = frame[n];
  assign sum  = (^data) ^ pbit;

  always_comb begin
    if (!par_en)    par_err = 1'b0;
    else if (stick) par_err = ~pbit;
    else            par_err = even ? sum : ~sum;
  end

  assign spos    = n + IDX_W'(par_en);
  assign frm_err = ~frame[spos] | (two_stop & ~frame[spos + IDX_W'(1)]);
endmodule

// File: rtl/ufc_timer.sv
module ufc_timer
  import uart_frame_pkg::*;
#(
  parameter int DIV_W  = UFC_DIV_W,
  parameter int IDX_W  = UFC_IDX_W,
  parameter int UNIT_W = UFC_UNIT_W,
  localparam int DUR_W = DIV_W + UNIT_W
) (
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             two_stop,
  input  logic [DIV_W-1:0] divisor,
  output logic [DUR_W-1:0] half_len
);
  logic [IDX_W-1:0]  n;
  logic [UNIT_W-1:0] units;

  assign n     = ufc_word_len(wlen);
  assign units = UNIT_W'({n, 1'b0}) + UNIT_W'(2) + UNIT_W'({par_en, 1'b0})
               + UNIT_W'(ufc_stop_halves(wlen, two_stop));
  assign half_len = DUR_W'(divisor) * DUR_W'(units);
endmodule

// File: rtl/uart_frame_codec.sv
module uart_frame_codec
  import uart_frame_pkg::*;
#(
  parameter int DATA_W  = UFC_DATA_W,
  parameter int DIV_W   = UFC_DIV_W,
  localparam int FRAME_W = DATA_W + 3,
  localparam int IDX_W   = $clog2(FRAME_W + 1),
  localparam int UNIT_W  = $clog2(2 * (FRAME_W + 1) + 1),
  localparam int DUR_W   = DIV_W + UNIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         lc_wlen,
  input  logic               lc_par_en,
  input  logic               lc_stick,
  input  logic               lc_even,
  input  logic               lc_two_stop,
  input  logic [DIV_W-1:0]   div_val,
  input  logic [DATA_W-1:0]  tx_byte,
  input  logic [FRAME_W-1:0] rx_frame,
  output logic [FRAME_W-1:0] tx_frame,
  output logic [IDX_W-1:0]   tx_bits,
  output logic [DATA_W+1:0]  rx_result,
  output logic [DUR_W-1:0]   char_half
);
  // named internal results, visible to the bound checker
  logic [FRAME_W-1:0] pk_frame;
  logic [IDX_W-1:0]   pk_bits;
  logic [DATA_W-1:0]  ck_data;
  logic               ck_perr;
  logic               ck_ferr;
  logic [DUR_W-1:0]   tm_half;

  ufc_packer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_packer (
    .wlen(lc_wlen), .par_en(lc_par_en), .stick(lc_stick), .even(lc_even),
    .two_stop(lc_two_stop), .data(tx_byte), .frame(pk_frame), .bits(pk_bits)
  );

  ufc_checker #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_checker (
    .wlen(lc_wlen), .par_en(lc_par_en), .stick(lc_stick), .even(lc_even),
    .two_stop(lc_two_stop), .frame(rx_frame), .data(ck_data),
    .par_err(ck_perr), .frm_err(ck_ferr)
  );

  ufc_timer #(.DIV_W(DIV_W), .IDX_W(IDX_W), .UNIT_W(UNIT_W)) u_timer (
    .wlen(lc_wlen), .par_en(lc_par_en), .two_stop(lc_two_stop),
    .divisor(div_val), .half_len(tm_half)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_frame  <= '0;
      tx_bits   <= '0;
      rx_result <= '0;
      char_half <= '0;
    end else begin
      tx_frame  <= pk_frame;
      tx_bits   <= pk_bits;
      rx_result <= {ck_ferr, ck_perr, ck_data};
      char_half <= tm_half;
    end
  end
endmodule

// File: rtl/uart_frame_codec_sva.sv
module uart_frame_codec_sva #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 11,
  parameter int IDX_W   = 4,
  parameter int DUR_W   = 21
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         lc_wlen,
  input logic               lc_par_en,
  input logic               lc_stick,
  input logic               lc_two_stop,
  input logic [FRAME_W-1:0] rx_frame,
  input logic [FRAME_W-1:0] tx_frame,
  input logic [DATA_W+1:0]  rx_result,
  input logic [DUR_W-1:0]   char_half,
  input logic [FRAME_W-1:0] pk_frame,
  input logic               ck_perr,
  input logic               ck_ferr
);
  logic             primed;
  logic [IDX_W-1:0] n_now;
  logic             rx_stick_zero;

  assign n_now         = IDX_W'(5) + IDX_W'(lc_wlen);
  assign rx_stick_zero = lc_par_en & lc_stick & ~rx_frame[n_now];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R4: stick parity bit is one on transmit
  assert_stick_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(lc_par_en && lc_stick) |-> tx_frame[$past(n_now)]);

  // R6: a zero in the stick position is reported
  assert_stick_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(rx_stick_zero) |-> rx_result[DATA_W]);

  // R10: no parity error without parity
  assert_no_perr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!lc_par_en) |-> !rx_result[DATA_W]);

  // R2: received data above the word length is clear
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (rx_result[DATA_W-1:0] >> $past(n_now)) == '0);

  // R9: an odd half count only arises from the 1.5 stop case
  assert_half_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!lc_two_stop || lc_wlen != 2'd0) |-> !char_half[0]);

  // R8: a frame built by the packer decodes clean under the same settings
  assert_loop_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame == pk_frame) |-> !ck_perr && !ck_ferr);
endmodule

bind uart_frame_codec uart_frame_codec_sva #(
  .DATA_W(DATA_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W), .DUR_W(DUR_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .lc_wlen(lc_wlen), .lc_par_en(lc_par_en),
  .lc_stick(lc_stick), .lc_two_stop(lc_two_stop), .rx_frame(rx_frame),
  .tx_frame(tx_frame), .rx_result(rx_result), .char_half(char_half),
  .pk_frame(pk_frame), .ck_perr(ck_perr), .ck_ferr(ck_ferr)
);

// File: tb/test_uart_frame_codec.sv
module test_uart_frame_codec;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {wlen[29:28], par[27], stick[26], even[25], two[24], data[23:16], div[15:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 16'd1},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, 16'd2},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5B, 16'd7},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 16'd3},
    {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hE3, 16'd5},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 16'd9},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7F, 16'd100},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81, 16'd27},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC0, 16'd0},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 16'hFFFF},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h15, 16'd13},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 16'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lc_wlen = 2'd3;
  logic        lc_par_en = 1'b1, lc_stick = 1'b0, lc_even = 1'b1, lc_two_stop = 1'b1;
  logic [15:0] div_val = 16'h1234;
  logic [7:0]  tx_byte = 8'hFF;
  logic [10:0] rx_frame = 11'h7FF;
  logic [10:0] tx_frame;
  logic [3:0]  tx_bits;
  logic [9:0]  rx_result;
  logic [20:0] char_half;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_codec i_uart_frame_codec (
    .clk(clk), .rst_n(rst_n), .lc_wlen(lc_wlen), .lc_par_en(lc_par_en),
    .lc_stick(lc_stick), .lc_even(lc_even), .lc_two_stop(lc_two_stop),
    .div_val(div_val), .tx_byte(tx_byte), .rx_frame(rx_frame),
    .tx_frame(tx_frame), .tx_bits(tx_bits), .rx_result(rx_result),
    .char_half(char_half)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reference: bits appended one after another
  function automatic logic [10:0] ref_frame(input logic [1:0] wl, input logic p, st, ev, tw,
                                            input logic [7:0] d);
    logic [10:0] f = '0;
    int k = 0;
    int ones = 0;
    for (int i = 0; i < 5 + wl; i++) begin
      f[k] = d[i];
      ones += d[i];
      k++;
    end
    if (p) begin
      f[k] = st ? 1'b1 : (ev ? ones[0] : ~ones[0]);
      k++;
    end
    f[k] = 1'b1;
    k++;
    if (tw) f[k] = 1'b1;
    return f;
  endfunction

  function automatic int ref_bits(input logic [1:0] wl, input logic p, tw);
    return 5 + wl + p + 1 + tw;
  endfunction

  // each frame element contributes its length in half bits
  function automatic longint ref_half(input logic [15:0] dv, input logic [1:0] wl,
                                      input logic p, tw);
    longint h = 2;
    h += 2 * (5 + wl);
    if (p) h += 2;
    if (!tw) h += 2;
    else if (wl == 2'd0) h += 3;
    else h += 4;
    return h * dv;
  endfunction

  task automatic set_lc(input logic [1:0] wl, input logic p, st, ev, tw);
    lc_wlen = wl; lc_par_en = p; lc_stick = st; lc_even = ev; lc_two_stop = tw;
  endtask

  task automatic rx_case(input string tag, input logic [10:0] fr, input logic [9:0] exp);
    @(negedge clk);
    rx_frame = fr;
    @(negedge clk);
    chk(rx_result == exp, tag, rx_result, exp);
  endtask

  initial begin
    // R11: reset clears every output
    repeat (2) @(negedge clk);
    chk(tx_frame == '0, "R11 reset tx_frame", tx_frame, 0);
    chk(tx_bits == '0, "R11 reset tx_bits", tx_bits, 0);
    chk(rx_result == '0, "R11 reset rx_result", rx_result, 0);
    chk(char_half == '0, "R11 reset char_half", char_half, 0);
    rst_n = 1'b1;

    // table walk: R1 R3 R4 R7 R9 on transmit, loop back for R5 R8 R2 on receive
    for (int v = 0; v < NVEC; v++) begin
      logic [10:0] ef;
      logic [7:0]  em;
      set_lc(VEC[v][29:28], VEC[v][27], VEC[v][26], VEC[v][25], VEC[v][24]);
      tx_byte = VEC[v][23:16];
      div_val = VEC[v][15:0];
      ef = ref_frame(lc_wlen, lc_par_en, lc_stick, lc_even, lc_two_stop, tx_byte);
      em = tx_byte & 8'((1 << (5 + lc_wlen)) - 1);
      rx_frame = ef;
      @(negedge clk);
      chk(tx_frame == ef, $sformatf("R1/R3/R4/R7 frame vec %0d", v), tx_frame, ef);
      chk(tx_bits == ref_bits(lc_wlen, lc_par_en, lc_two_stop),
          $sformatf("R7 bits vec %0d", v), tx_bits, ref_bits(lc_wlen, lc_par_en, lc_two_stop));
      chk(char_half == ref_half(div_val, lc_wlen, lc_par_en, lc_two_stop),
          $sformatf("R9 half vec %0d", v), char_half,
          ref_half(div_val, lc_wlen, lc_par_en, lc_two_stop));
      chk(rx_result == {2'b00, em}, $sformatf("R2/R5/R8 loopback vec %0d", v),
          rx_result, {2'b00, em});
    end

    // R9: fixed durations, including the 1.5 stop case and the largest product
    @(negedge clk);
    set_lc(2'd0, 1'b0, 1'b0, 1'b0, 1'b1); div_val = 16'd3;
    @(negedge clk);
    chk(char_half == 21'd45, "R9 one-and-half stop", char_half, 45);
    set_lc(2'd3, 1'b1, 1'b0, 1'b0, 1'b1); div_val = 16'hFFFF;
    @(negedge clk);
    chk(char_half == 21'd1572840, "R9 max duration", char_half, 1572840);

    // R5: even parity with a flipped parity bit; same image valid under odd
    set_lc(2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    rx_case("R5 even flipped", 11'h35A, 10'h15A);
    set_lc(2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    rx_case("R5 odd correct", 11'h35A, 10'h05A);
    // R6: stick parity, zero flagged, one accepted regardless of even select
    set_lc(2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    rx_case("R6 stick zero", 11'h25A, 10'h15A);
    set_lc(2'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    rx_case("R6 stick one", 11'h35A, 10'h05A);
    // R8: stop bit faults, and the second position ignored with one stop
    set_lc(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_case("R8 first stop zero", 11'h05A, 10'h25A);
    set_lc(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    rx_case("R8 second stop zero", 11'h15A, 10'h25A);
    set_lc(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_case("R8 second ignored", 11'h15A, 10'h05A);
    // R2: upper bits of a 5-bit word cleared
    set_lc(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_case("R2 five bit word", 11'h7FF, 10'h01F);
    // R10: parity disabled never reports parity error
    set_lc(2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    rx_case("R10 no parity", 11'h07F, 10'h03F);
    // R2: transmit bits beyond the frame are zero
    @(negedge clk);
    set_lc(2'd0, 1'b0, 1'b0, 1'b0, 1'b0); tx_byte = 8'hFF;
    @(negedge clk);
    chk(tx_frame == 11'h03F, "R2 tx upper zero", tx_frame, 11'h03F);

    // R11: one clock of latency
    tx_byte = 8'h00;
    #1;
    chk(tx_frame == 11'h03F, "R11 holds before edge", tx_frame, 11'h03F);
    @(negedge clk);
    chk(tx_frame == 11'h020, "R11 updates after edge", tx_frame, 11'h020);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule